// File: doc/BRIEF.md
# Run-time Programmable 4-bit Shift-Register Sequence Generator

The block holds a 4-bit state and, on each enabled clock, moves it one place toward the low end. The bit that enters at the top is the XOR of those state bits whose matching bit in a 4-bit tap word is set. The tap word is an input, so one instance can follow any recurrence of the form s_j = c1·s_{j-1} ⊕ c2·s_{j-2} ⊕ c3·s_{j-3} ⊕ c4·s_{j-4}. That recurrence corresponds to the connection polynomial 1 + c1·D + c2·D² + c3·D³ + c4·D⁴. Tap words 0x9 and 0x3 give maximal sequences of length 15. Other words, such as 0xB and 0xD, give shorter cycles that differ from those.

A user seeds the register through a load strobe, or resets it to 0001. The user then steps it with the enable input. Each step depends only on the state and the tap word, so a given seed and tap word always replay the same sequence. An all-zero state is legal. It is a fixed point and the register simply stays there.

Top module: `prog_lfsr4`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes 4'b0001 after that edge, whatever `load` and `en` are.
- R2: When `load` is high and `rst` is low at an edge, `state` takes the value of `seed`, even if `en` is also high.
- R3: When only `en` is high at an edge, the new `state[2:0]` equals the old `state[3:1]`. The new `state[3]` is the XOR over i of `taps[i] & state[i]`. In this mapping `taps[3]` is c1, the tap on the newest bit `state[3]`, and `taps[0]` is c4, the tap on the oldest bit `state[0]`.
- R4: When `rst`, `load` and `en` are all low, `state` keeps its value, even if `taps` changes. A new tap word is used first on the next enabled step.
- R5: An all-zero `state` stays all-zero on enabled steps for every tap word.
- R6: Starting from any nonzero seed, tap word 0x9 (new bit = state[3] ⊕ state[0]) and tap word 0x3 (new bit = state[1] ⊕ state[0]) each return to the seed after exactly 15 steps.
- R7: From seed 0001, tap words 0x3, 0x9, 0xB and 0xD produce four mutually different 15-step state sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, sets the state to 0001 |
| load | input | 1 | Synchronous seed strobe, takes priority over stepping |
| seed | input | 4 | Value copied into the state on a load |
| en | input | 1 | Step enable |
| taps | input | 4 | Tap word; bit 3 is c1, bit 0 is c4 |
| state | output | 4 | Current register contents; bit 3 is the newest bit |

## Verification
Two collisions matter for this block. A load can arrive in the same cycle as a step, and a reset can arrive in the same cycle as a load. The bench raises `load` and `en` together with a seed that differs from the would-be shifted value, then expects the seed. It also raises `rst` with `load` and a nonzero seed, then expects 0001. In both cases the following cycle shows which operation won. The main sweep drives every tap word with every seed and compares each step against a next-state function computed in the bench.

// File: rtl/prog_lfsr4.sv
module prog_lfsr4 #(
  parameter logic [3:0] RESET_STATE = 4'b0001
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] seed,
  input  logic       en,
  input  logic [3:0] taps,
  output logic [3:0] state
);

  logic       fb;
  logic [3:0] q;

  assign fb    = ^(taps & q);
  assign state = q;

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_STATE;
    else if (load) q <= seed;
    else if (en)   q <= {fb, q[3:1]};
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> state == RESET_STATE);

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed));

  assert_shift_low_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> state[2:0] == $past(state[3:1]));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(state));

  assert_zero_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state == 4'b0000) |=> state == 4'b0000);

endmodule

// File: tb/tb_prog_lfsr4.sv
module tb_prog_lfsr4;
  logic       clk = 1'b0;
  logic       rst, load, en;
  logic [3:0] seed, taps;
  logic [3:0] state;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  prog_lfsr4 dut (.clk(clk), .rst(rst), .load(load), .seed(seed),
                  .en(en), .taps(taps), .state(state));

  always #5ns clk = ~clk;

  function automatic logic [3:0] nxt(input logic [3:0] q, input logic [3:0] c);
    logic b;
    b = 1'b0;
    for (int i = 0; i < 4; i++) b = b ^ (c[i] & q[i]);
    return {b, q[3:1]};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (state !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, state, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic l, input logic [3:0] s,
                     input logic e, input logic [3:0] c);
    rst = r; load = l; seed = s; en = e; taps = c;
    @(negedge clk);
  endtask

  function automatic int period_of(input logic [3:0] c, input logic [3:0] s);
    logic [3:0] q;
    q = s;
    for (int n = 1; n <= 16; n++) begin
      q = nxt(q, c);
      if (q == s) return n;
    end
    return 0;
  endfunction

  logic [3:0] seqs [4][15];

  initial begin
    logic [3:0] exp;
    logic [3:0] tw [4];
    tw[0] = 4'h3; tw[1] = 4'h9; tw[2] = 4'hB; tw[3] = 4'hD;
    rst = 1'b1; load = 1'b0; en = 1'b0; seed = 4'h0; taps = 4'h0;
    @(negedge clk);
    cyc(1'b1, 1'b0, 4'h0, 1'b0, 4'h0);
    chk("R1 reset state", 4'b0001);

    // R3 / R2: full sweep over tap words and seeds
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 16; s++) begin
        cyc(1'b0, 1'b1, 4'(s), 1'b0, 4'(c));
        chk("R2 load", 4'(s));
        exp = 4'(s);
        for (int k = 0; k < 18; k++) begin
          exp = nxt(exp, 4'(c));
          cyc(1'b0, 1'b0, 4'h0, 1'b1, 4'(c));
          if (s == 0) chk("R5 zero holds", 4'h0);
          else        chk("R3 step", exp);
        end
      end
    end

    // R2: load and enable in the same cycle
    cyc(1'b0, 1'b1, 4'b1000, 1'b0, 4'h9);
    cyc(1'b0, 1'b1, 4'b0110, 1'b1, 4'h9);
    chk("R2 load beats step", 4'b0110);

    // R1: reset and load in the same cycle
    cyc(1'b1, 1'b1, 4'b1110, 1'b1, 4'h9);
    chk("R1 reset beats load", 4'b0001);

    // R4: hold with changing taps, new taps used on next step
    cyc(1'b0, 1'b1, 4'b1011, 1'b0, 4'h9);
    for (int c = 0; c < 16; c++) begin
      cyc(1'b0, 1'b0, 4'hF, 1'b0, 4'(c));
      chk("R4 hold", 4'b1011);
    end
    cyc(1'b0, 1'b0, 4'h0, 1'b1, 4'h3);
    chk("R4 new taps on step", nxt(4'b1011, 4'h3));

    // R6: period 15 for 0x9 and 0x3 from every nonzero seed
    for (int t = 0; t < 2; t++) begin
      for (int s = 1; s < 16; s++) begin
        int n;
        logic [3:0] c;
        c = (t == 0) ? 4'h9 : 4'h3;
        cyc(1'b0, 1'b1, 4'(s), 1'b0, c);
        n = 0;
        for (int k = 1; k <= 16; k++) begin
          cyc(1'b0, 1'b0, 4'h0, 1'b1, c);
          if (state == 4'(s)) begin n = k; break; end
        end
        checks++;
        if (n != 15) begin
          fails++;
          $display("FAIL R6 period actual=%0d expected=15 taps=%h seed=%h", n, c, s);
        end
      end
    end

    // R7: distinct sequences from seed 0001
    for (int t = 0; t < 4; t++) begin
      cyc(1'b0, 1'b1, 4'b0001, 1'b0, tw[t]);
      for (int k = 0; k < 15; k++) begin
        cyc(1'b0, 1'b0, 4'h0, 1'b1, tw[t]);
        seqs[t][k] = state;
      end
    end
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++) begin
        bit same;
        same = 1'b1;
        for (int k = 0; k < 15; k++) if (seqs[a][k] != seqs[b][k]) same = 1'b0;
        checks++;
        if (same) begin
          fails++;
          $display("FAIL R7 sequences equal actual=same expected=different taps %h vs %h",
                   tw[a], tw[b]);
        end
      end
    if (period_of(4'h9, 4'b0001) != 15) $display("note: model period mismatch");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule